// File: doc/BRIEF.md
# Field-Encoded Microprogrammed Control Unit

This block is the output stage of a microprogrammed controller whose control store keeps each microinstruction in compressed form. Six microoperations are split into two groups. No stored microinstruction ever asserts two microoperations from the same group. Each group is therefore packed into a small binary field instead of one bit per microoperation. A field for a group of n microoperations is ceil(log2(n+1)) bits wide, and its all-zero code means that no microoperation of that group is active. The two fields are concatenated into a 4-bit stored word, so the four-word store needs 16 bits rather than the 24 bits of the one-hot form, a saving of about a third.

A sequencer outside the block presents a word address. The block reads the compressed word, expands every field through its own decoder, and registers the merged 6-bit microoperation vector. A separate combinational encoder performs the reverse mapping. It takes a raw microoperation vector and produces the compressed word. It also raises an error flag when a group has more than one active microoperation, and writes the zero code into each offending field.

Top module: `uop_field_ctrl`

## Requirements
- R1: When rst_n is sampled low at a rising clock edge, uops is all zero after that edge.
- R2: The uops vector is registered. It reflects the address sampled at the previous rising edge, one cycle of latency, with no combinational path from addr.
- R3: uops bit k stands for microoperation y(k+1). Address 0 gives y2 and y6 (6'b100010). Address 1 gives y2 and y4 (6'b001010). Address 2 gives y1 and y5 (6'b010001). Address 3 gives y3 and y5 (6'b010100).
- R4: Stored word bits [3:2] form field A: 01 is y2, 10 is y1, 11 is y3. Bits [1:0] form field B: 01 is y6, 10 is y4, 11 is y5. Code 00 in either field asserts nothing from that group. The stored words for addresses 0 to 3 are 0101, 0110, 1011 and 1111.
- R5: uops never has more than one bit set within y1..y3 (bits [2:0]) or within y4..y6 (bits [5:3]).
- R6: For a raw vector with at most one active microoperation per group, enc_word gives the field codes of R4, placed at the bit positions of R4. A group with no active bit encodes as 00, and enc_err is 0.
- R7: When a group in enc_raw has two or more bits set, enc_err is 1 and that group's field in enc_word is 00. A group with at most one bit set still encodes as in R6.
- R8: Encoding the decoded pattern of each address gives back the stored word of that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 2 | Microinstruction address |
| uops | output | 6 | Registered microoperation vector, bit k = y(k+1) |
| enc_raw | input | 6 | Raw microoperation vector to encode, bit k = y(k+1) |
| enc_word | output | 4 | Compressed word produced from enc_raw |
| enc_err | output | 1 | More than one active microoperation in a group |

## Verification
The decoded vector is due exactly one rising edge after an address is applied. The driver changes addr on a falling edge and queues the expected pattern. The monitor removes one entry per rising edge and compares it 1 ns after that edge, so each comparison falls in the cycle that follows the capture. The encoder has no registers, so its word and flag are checked in the same cycle, 1 ns after enc_raw changes and well before the next edge. The reset value is checked after an edge taken with rst_n low, both at start-up and after a reset applied in the middle of a run.

// File: rtl/uop_pkg.sv
// Shared constants for the field-encoded control unit.
// Assumes every group has the same size and occupies contiguous uop bits.
package uop_pkg;
    localparam int NUM_OPS    = 6;
    localparam int NUM_FIELDS = 2;
    localparam int GROUP_SIZE = NUM_OPS / NUM_FIELDS;
    localparam int FIELD_W    = $clog2(GROUP_SIZE + 1);
    localparam int NUM_CODES  = 1 << FIELD_W;
    localparam int WORD_W     = NUM_FIELDS * FIELD_W;
    localparam int DEPTH      = 4;
    localparam int ADDR_W     = $clog2(DEPTH);

    // Microoperation index selected by each code of each field; -1 marks the idle code.
    // Field 0 sits in the most significant bits of the stored word.
    localparam int FIELD_MAP [NUM_FIELDS][NUM_CODES] = '{
        '{-1, 1, 0, 2},
        '{-1, 5, 3, 4}
    };

    // Compressed control store image, index 0 first.
    localparam logic [WORD_W-1:0] STORE_IMG [DEPTH] = '{
        4'b0101, 4'b0110, 4'b1011, 4'b1111
    };
endpackage

// File: rtl/uop_ctrl_rom.sv
// Compressed control store: returns the stored word for an address.
// Assumes the store is small enough to build from logic.
module uop_ctrl_rom
    import uop_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    // Look up the word held at the address.
    always_comb begin
        word = STORE_IMG[addr];
    end
endmodule

// File: rtl/uop_field_decoder.sv
// Expands one binary field into the microoperation vector of its group.
// Assumes code 0 is idle and the other codes select one microoperation each.
module uop_field_decoder
    import uop_pkg::*;
#(
    parameter int FIELD_IDX = 0
) (
    input  logic [FIELD_W-1:0]  code,
    output logic [NUM_OPS-1:0]  ops
);
    // Assert the single microoperation selected by a non-idle code.
    always_comb begin
        ops = '0;
        for (int c = 1; c < NUM_CODES; c++) begin
            if (FIELD_MAP[FIELD_IDX][c] >= 0 && code == FIELD_W'(c)) begin
                ops[FIELD_MAP[FIELD_IDX][c]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/uop_field_encoder.sv
// Maps the raw microoperation vector of one group to that group's field code.
// Flags a conflict and outputs code 0 when two or more members are active.
module uop_field_encoder
    import uop_pkg::*;
#(
    parameter int FIELD_IDX = 0
) (
    input  logic [NUM_OPS-1:0]  raw,
    output logic [FIELD_W-1:0]  code,
    output logic                conflict
);
    int hits;
    logic [FIELD_W-1:0] pick;

    // Count the active members and note the code of the last one seen.
    always_comb begin
        hits = 0;
        pick = '0;
        for (int c = 1; c < NUM_CODES; c++) begin
            if (FIELD_MAP[FIELD_IDX][c] >= 0 && raw[FIELD_MAP[FIELD_IDX][c]]) begin
                hits = hits + 1;
                pick = FIELD_W'(c);
            end
        end
        conflict = (hits > 1);
        code     = conflict ? '0 : pick;
    end
endmodule

// File: rtl/uop_field_ctrl.sv
// Top of the field-encoded control unit: store, per-field decoders,
// registered microoperation vector, and the combinational encoder path.
// Assumes the groups are disjoint, so the decoder outputs can be ORed.
module uop_field_ctrl
    import uop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_OPS-1:0]   uops,
    input  logic [NUM_OPS-1:0]   enc_raw,
    output logic [WORD_W-1:0]    enc_word,
    output logic                 enc_err
);
    logic [WORD_W-1:0]  rom_word;
    logic [NUM_OPS-1:0] dec_ops  [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] conflicts;
    logic [NUM_OPS-1:0] dec_all;

    uop_ctrl_rom u_rom (.addr(addr), .word(rom_word));

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int LSB = (NUM_FIELDS - 1 - f) * FIELD_W;

        uop_field_decoder #(.FIELD_IDX(f)) u_dec (
            .code (rom_word[LSB +: FIELD_W]),
            .ops  (dec_ops[f])
        );

        uop_field_encoder #(.FIELD_IDX(f)) u_enc (
            .raw      (enc_raw),
            .code     (enc_word[LSB +: FIELD_W]),
            .conflict (conflicts[f])
        );
    end

    // Merge the per-field decoder outputs.
    always_comb begin
        dec_all = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            dec_all = dec_all | dec_ops[f];
        end
    end

    assign enc_err = |conflicts;

    // Register the decoded vector; reset clears every microoperation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uops <= '0;
        end else begin
            uops <= dec_all;
        end
    end
endmodule

// File: rtl/uop_field_ctrl_chk.sv
// Property checker for uop_field_ctrl, attached by bind below.
module uop_field_ctrl_chk
    import uop_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic [NUM_OPS-1:0]  uops,
    input logic [NUM_OPS-1:0]  enc_raw,
    input logic [WORD_W-1:0]   enc_word,
    input logic                enc_err
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (uops == '0));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(addr)) |=> $stable(uops));

    p_group_a_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(uops[GROUP_SIZE-1:0]));

    p_group_b_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(uops[NUM_OPS-1:GROUP_SIZE]));

    p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enc_err == (($countones(enc_raw[GROUP_SIZE-1:0]) > 1) ||
                    ($countones(enc_raw[NUM_OPS-1:GROUP_SIZE]) > 1)));

    p_err_zero_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(enc_raw[GROUP_SIZE-1:0]) > 1) |-> (enc_word[WORD_W-1 -: FIELD_W] == '0));

    p_err_zero_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(enc_raw[NUM_OPS-1:GROUP_SIZE]) > 1) |-> (enc_word[FIELD_W-1:0] == '0));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_raw == '0) |-> (enc_word == '0 && !enc_err));
endmodule

bind uop_field_ctrl uop_field_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .uops(uops),
    .enc_raw(enc_raw), .enc_word(enc_word), .enc_err(enc_err)
);

// File: tb/tb_uop_field_ctrl.sv
module tb_uop_field_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic [5:0] uops;
    logic [5:0] enc_raw = '0;
    logic [3:0] enc_word;
    logic       enc_err;

    int checks = 0;
    int errors = 0;

    // Scoreboard entry: expected uops plus the requirement tag.
    typedef struct { logic [5:0] exp; string req; } sb_item_t;
    sb_item_t sbq[$];

    // Uncompressed reference patterns, bit k = y(k+1).
    logic [5:0] ref_ops [4] = '{6'b100010, 6'b001010, 6'b010001, 6'b010100};
    logic [3:0] ref_word [4] = '{4'b0101, 4'b0110, 4'b1011, 4'b1111};

    uop_field_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .uops(uops),
        .enc_raw(enc_raw), .enc_word(enc_word), .enc_err(enc_err)
    );

    always #2 clk = ~clk;

    task automatic check6(string req, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_enc(string req, logic [5:0] raw, logic [3:0] w, logic e);
        @(negedge clk);
        enc_raw = raw;
        #1;
        checks++;
        if (enc_word !== w || enc_err !== e) begin
            errors++;
            $display("FAIL %s: raw %b got word %b err %b expected word %b err %b",
                     req, raw, enc_word, enc_err, w, e);
        end
    endtask

    // Driver: present an address at a falling edge and queue the expected result.
    task automatic drive_addr(logic [1:0] a, string req);
        sb_item_t it;
        @(negedge clk);
        addr = a;
        it.exp = ref_ops[a];
        it.req = req;
        sbq.push_back(it);
    endtask

    // Monitor: compare one queued item 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                check6(it.req, uops, it.exp);
            end
        end
    end

    task automatic run_tests();
        // R1: start-up reset value.
        repeat (2) @(posedge clk);
        #1;
        check6("R1", uops, 6'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3/R4: every address, ascending then in a mixed order.
        for (int a = 0; a < 4; a++) drive_addr(2'(a), "R3");
        drive_addr(2'd3, "R2");
        drive_addr(2'd0, "R4");
        drive_addr(2'd2, "R2");
        drive_addr(2'd1, "R4");
        drive_addr(2'd1, "R2");
        @(posedge clk);
        #2;

        // R1: reset in mid-run clears the vector.
        @(negedge clk);
        addr = 2'd3;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check6("R1", uops, 6'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive_addr(2'd2, "R2");
        @(posedge clk);
        #2;

        // R8: round trip of each reference pattern.
        for (int a = 0; a < 4; a++) check_enc("R8", ref_ops[a], ref_word[a], 1'b0);
        // R6: legal patterns, including idle groups.
        check_enc("R6", 6'b000000, 4'b0000, 1'b0);
        check_enc("R6", 6'b000001, 4'b1000, 1'b0);
        check_enc("R6", 6'b000100, 4'b1100, 1'b0);
        check_enc("R6", 6'b001000, 4'b0010, 1'b0);
        // R7: conflicting groups.
        check_enc("R7", 6'b000011, 4'b0000, 1'b1);
        check_enc("R7", 6'b100011, 4'b0001, 1'b1);
        check_enc("R7", 6'b111100, 4'b1100, 1'b1);
        check_enc("R7", 6'b111111, 4'b0000, 1'b1);
    endtask

    initial begin
        fork
            run_tests();
            begin
                #(4 * 20000);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule